// File: doc/BRIEF.md
# Ethernet Transmit Frame Finisher

This block sits between a transmit frame buffer and a byte-wide MAC transmit path. It accepts frame bytes from a valid/ready stream that carries an end-of-frame marker and a frame tag. It passes the bytes on one cycle later. Depending on two per-frame options, it fills short frames with zero bytes up to the Ethernet minimum and appends a CRC-32 frame check sequence.

A run/stop enable decides whether new frames are taken. The enable is looked at only between frames, so a frame that has started always finishes. A byte stream that runs dry in the middle of a frame is a fatal underrun. The frame is aborted, the condition is latched, and the block stays silent until reset.

After every frame, the block pulses a status strobe. The status word carries the frame tag and collision flags gathered from the MAC side during that frame. It also shows the sticky underrun flag.

Top module: `eth_tx_finisher`

## Requirements
- R1: A byte accepted on the input (`in_valid` and `in_ready` both high at a clock edge) appears on `out_data` with `out_valid` high in the next cycle. Bytes keep their order. When neither padding nor CRC applies, the final input byte carries `out_last`.
- R2: When `crc_enable` is high at frame start, four check bytes follow the last data or pad byte. They are the reflected CRC-32 (polynomial 0x04C11DB7, reflected form 0xEDB88320, preset all ones, result inverted), sent least significant byte first, and the fourth carries `out_last`. For the nine ASCII bytes "123456789" the check value is 0xCBF43926, sent as 26 39 F4 CB.
- R3: When `pad_enable` and `crc_enable` are both high at frame start and the frame has fewer than 60 data bytes, zero bytes are inserted after the data up to byte 60. Then the 4 check bytes follow, for 64 bytes in all. The CRC covers the pad bytes.
- R4: A padded-mode frame of 60 or more data bytes gets no pad bytes, only the 4 check bytes.
- R5: `pad_enable` without `crc_enable` has no effect. The frame is sent unpadded and without check bytes.
- R6: While idle, `in_ready` is high only when `tx_enable` is high and no underrun is latched. With `tx_enable` low, no frame starts and nothing is output.
- R7: Dropping `tx_enable` during a frame does not shorten it. All remaining data, pad and check bytes are still sent, and only then does the block stop taking frames.
- R8: If `in_valid` is low while a frame is between its first and last byte, the frame is aborted and `status_underrun` rises. `status_underrun` stays high, with no further output and `in_ready` low, until reset. A status strobe reports the aborted frame's tag.
- R9: `status_valid` pulses one cycle after each byte marked `out_last`. It reports in `status_fid` the 6-bit tag given with that frame's first byte.
- R10: `status_late_coll` and `status_max_coll` report whether the matching MAC indication was high during the reported frame. They start clear for every new frame.
- R11: `in_ready` is low while pad or check bytes are being emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_enable | input | 1 | Run (1) / stop (0), checked between frames |
| pad_enable | input | 1 | Pad short frames (needs crc_enable) |
| crc_enable | input | 1 | Append CRC-32 check bytes |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted this cycle if valid |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Marks the final data byte of a frame |
| in_fid | input | 6 | Frame tag, sampled with the first byte |
| late_coll | input | 1 | Late collision indication from MAC |
| max_coll | input | 1 | Excess collision indication from MAC |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output frame byte |
| out_last | output | 1 | Final byte of the output frame |
| status_valid | output | 1 | One-cycle status strobe |
| status_fid | output | 6 | Tag of the reported frame |
| status_late_coll | output | 1 | Late collision seen in reported frame |
| status_max_coll | output | 1 | Excess collision seen in reported frame |
| status_underrun | output | 1 | Sticky fatal underrun flag |

## Verification
The bench targets the padding boundary with frames of 59, 60 and 70 data bytes. A design with an off-by-one pad limit would emit one byte too many or too few there, and a CRC that skipped the pad bytes would produce the wrong check bytes. It drops the enable in the middle of a padded frame, which exposes a design that truncates or drops its check bytes. It then stalls the input in the middle of a frame, which shows whether the underrun is sticky or lets later frames leak out. Back-to-back one-byte frames and frames with and without collision pulses show whether the status strobe timing, the frame tag and the per-frame clearing of the collision flags are right.

// File: rtl/etf_pkg.sv
package etf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_PAD  = 2'd2,
    ST_FCS  = 2'd3
  } seq_state_e;

  localparam int unsigned FCS_BYTES     = 4;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // one byte of the reflected CRC-32 shift, LSB first
  function automatic logic [31:0] crc_byte(input logic [31:0] c_in, input logic [7:0] b);
    logic [31:0] c;
    c = c_in ^ {24'h0, b};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/etf_crc32.sv
module etf_crc32
  import etf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        adv,
  input  logic [7:0]  din,
  output logic [31:0] crc_q
);

  logic [31:0] crc_d;

  always_comb begin
    crc_d = crc_q;
    if (adv) begin
      crc_d = crc_byte(start ? 32'hFFFF_FFFF : crc_q, din);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= 32'hFFFF_FFFF;
    end else if (adv) begin
      crc_q <= crc_d;
    end
  end

endmodule

// File: rtl/etf_sequencer.sv
module etf_sequencer
  import etf_pkg::*;
#(
  parameter int unsigned MIN_LEN = 64,
  parameter int unsigned FID_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_enable,
  input  logic             pad_enable,
  input  logic             crc_enable,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic [FID_W-1:0] in_fid,
  input  logic [31:0]      crc_val,
  output logic             in_ready,
  output logic             crc_start,
  output logic             crc_adv,
  output logic [7:0]       crc_din,
  output logic             frame_start,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             frame_done,
  output logic [FID_W-1:0] cur_fid,
  output logic             fatal
);

  localparam int unsigned PAD_TARGET = MIN_LEN - FCS_BYTES;
  localparam int unsigned CNT_W      = $clog2(PAD_TARGET + 1);
  localparam int unsigned IDX_W      = $clog2(FCS_BYTES);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             padm_q, padm_d, crcm_q, crcm_d;
  logic [FID_W-1:0] fid_q, fid_d;
  logic             fatal_q, fatal_d;
  logic             ov_d, ol_d, done_d;
  logic [7:0]       od_d;
  logic             accept, cur_pad, cur_crc, need_pad;

  assign in_ready = !fatal_q && ((st_q == ST_IDLE && tx_enable) || st_q == ST_DATA);
  assign accept   = in_valid && in_ready;
  assign cur_pad  = (st_q == ST_IDLE) ? (pad_enable && crc_enable) : padm_q;
  assign cur_crc  = (st_q == ST_IDLE) ? crc_enable : crcm_q;
  assign cnt_inc  = (cnt_q == CNT_W'(PAD_TARGET)) ? cnt_q : cnt_q + 1'b1;
  assign need_pad = cur_pad && (cnt_inc < CNT_W'(PAD_TARGET));

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    idx_d       = idx_q;
    padm_d      = padm_q;
    crcm_d      = crcm_q;
    fid_d       = fid_q;
    fatal_d     = fatal_q;
    ov_d        = 1'b0;
    od_d        = 8'h00;
    ol_d        = 1'b0;
    done_d      = 1'b0;
    crc_start   = 1'b0;
    crc_adv     = 1'b0;
    crc_din     = in_data;
    frame_start = 1'b0;
    if (accept) begin
      ov_d    = 1'b1;
      od_d    = in_data;
      crc_adv = 1'b1;
      cnt_d   = cnt_inc;
      if (st_q == ST_IDLE) begin
        frame_start = 1'b1;
        crc_start   = 1'b1;
        padm_d      = cur_pad;
        crcm_d      = cur_crc;
        fid_d       = in_fid;
        st_d        = ST_DATA;
      end
      if (in_last) begin
        if (need_pad) begin
          st_d = ST_PAD;
        end else if (cur_crc) begin
          st_d  = ST_FCS;
          idx_d = '0;
        end else begin
          st_d   = ST_IDLE;
          ol_d   = 1'b1;
          done_d = 1'b1;
          cnt_d  = '0;
        end
      end
    end else begin
      case (st_q)
        ST_DATA: begin
          fatal_d = 1'b1;
          st_d    = ST_IDLE;
          done_d  = 1'b1;
          cnt_d   = '0;
        end
        ST_PAD: begin
          ov_d    = 1'b1;
          crc_adv = 1'b1;
          crc_din = 8'h00;
          cnt_d   = cnt_inc;
          if (cnt_inc == CNT_W'(PAD_TARGET)) begin
            st_d  = ST_FCS;
            idx_d = '0;
          end
        end
        ST_FCS: begin
          ov_d  = 1'b1;
          od_d  = ~crc_val[8*idx_q +: 8];
          idx_d = idx_q + 1'b1;
          if (idx_q == IDX_W'(FCS_BYTES - 1)) begin
            st_d   = ST_IDLE;
            ol_d   = 1'b1;
            done_d = 1'b1;
            cnt_d  = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      padm_q     <= 1'b0;
      crcm_q     <= 1'b0;
      fid_q      <= '0;
      fatal_q    <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= 8'h00;
      out_last   <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      idx_q      <= idx_d;
      fatal_q    <= fatal_d;
      out_valid  <= ov_d;
      out_data   <= od_d;
      out_last   <= ol_d;
      frame_done <= done_d;
      if (frame_start) begin
        padm_q <= padm_d;
        crcm_q <= crcm_d;
        fid_q  <= fid_d;
      end
    end
  end

  assign cur_fid = fid_q;
  assign fatal   = fatal_q;

  // R8
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_q |=> fatal_q);

  // R3
  pad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FCS && idx_q == '0 && padm_q) |-> (cnt_q == CNT_W'(PAD_TARGET)));

  // R7
  stop_no_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && in_valid && !tx_enable) |=> out_valid);

endmodule

// File: rtl/etf_status.sv
module etf_status #(
  parameter int unsigned FID_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             frame_done,
  input  logic [FID_W-1:0] cur_fid,
  input  logic             late_coll,
  input  logic             max_coll,
  output logic             status_valid,
  output logic [FID_W-1:0] status_fid,
  output logic             status_late_coll,
  output logic             status_max_coll
);

  logic       late_acc_q, late_acc_d, max_acc_q, max_acc_d;

  always_comb begin
    if (frame_start) begin
      late_acc_d = late_coll;
      max_acc_d  = max_coll;
    end else begin
      late_acc_d = late_acc_q | late_coll;
      max_acc_d  = max_acc_q | max_coll;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      late_acc_q       <= 1'b0;
      max_acc_q        <= 1'b0;
      status_valid     <= 1'b0;
      status_fid       <= '0;
      status_late_coll <= 1'b0;
      status_max_coll  <= 1'b0;
    end else begin
      late_acc_q   <= late_acc_d;
      max_acc_q    <= max_acc_d;
      status_valid <= frame_done;
      if (frame_done) begin
        status_fid       <= cur_fid;
        status_late_coll <= late_acc_q | late_coll;
        status_max_coll  <= max_acc_q | max_coll;
      end
    end
  end

endmodule

// File: rtl/eth_tx_finisher.sv
module eth_tx_finisher #(
  parameter int unsigned MIN_LEN = 64,
  parameter int unsigned FID_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_enable,
  input  logic             pad_enable,
  input  logic             crc_enable,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic [FID_W-1:0] in_fid,
  input  logic             late_coll,
  input  logic             max_coll,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             status_valid,
  output logic [FID_W-1:0] status_fid,
  output logic             status_late_coll,
  output logic             status_max_coll,
  output logic             status_underrun
);

  logic             crc_start, crc_adv, frame_start, frame_done, fatal;
  logic [7:0]       crc_din;
  logic [31:0]      crc_val;
  logic [FID_W-1:0] cur_fid;

  etf_crc32 i_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .start (crc_start),
    .adv   (crc_adv),
    .din   (crc_din),
    .crc_q (crc_val)
  );

  etf_sequencer #(.MIN_LEN(MIN_LEN), .FID_W(FID_W)) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_enable   (tx_enable),
    .pad_enable  (pad_enable),
    .crc_enable  (crc_enable),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_last     (in_last),
    .in_fid      (in_fid),
    .crc_val     (crc_val),
    .in_ready    (in_ready),
    .crc_start   (crc_start),
    .crc_adv     (crc_adv),
    .crc_din     (crc_din),
    .frame_start (frame_start),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_last    (out_last),
    .frame_done  (frame_done),
    .cur_fid     (cur_fid),
    .fatal       (fatal)
  );

  etf_status #(.FID_W(FID_W)) i_stat (
    .clk              (clk),
    .rst_n            (rst_n),
    .frame_start      (frame_start),
    .frame_done       (frame_done),
    .cur_fid          (cur_fid),
    .late_coll        (late_coll),
    .max_coll         (max_coll),
    .status_valid     (status_valid),
    .status_fid       (status_fid),
    .status_late_coll (status_late_coll),
    .status_max_coll  (status_max_coll)
  );

  assign status_underrun = fatal;

  // R9
  last_then_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |=> status_valid);

  // R8
  silent_after_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_underrun |-> !out_valid);

endmodule

// File: tb/test_eth_tx_finisher.sv
`timescale 1ns/1ps
module test_eth_tx_finisher;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_enable, pad_enable, crc_enable;
  logic       in_valid, in_ready, in_last;
  logic [7:0] in_data;
  logic [5:0] in_fid;
  logic       late_coll, max_coll;
  logic       out_valid, out_last;
  logic [7:0] out_data;
  logic       status_valid, status_late_coll, status_max_coll, status_underrun;
  logic [5:0] status_fid;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;
  bit prev_last = 0;

  logic [8:0] exp_b[$];
  string      tag_b[$];
  logic [8:0] exp_s[$];
  string      tag_s[$];

  always #2.5 clk = ~clk;

  eth_tx_finisher i_eth_tx_finisher (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .pad_enable(pad_enable),
    .crc_enable(crc_enable), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_fid(in_fid),
    .late_coll(late_coll), .max_coll(max_coll), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .status_valid(status_valid),
    .status_fid(status_fid), .status_late_coll(status_late_coll),
    .status_max_coll(status_max_coll), .status_underrun(status_underrun)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c_in, input logic [7:0] b);
    logic [31:0] c;
    c = c_in;
    for (int k = 0; k < 8; k++) begin
      if ((c[0] ^ b[k]) == 1'b1) c = (c >> 1) ^ 32'hEDB88320;
      else c = c >> 1;
    end
    return c;
  endfunction

  function automatic logic [7:0] gen_byte(input int seed, input int i);
    if (seed < 0) return 8'(8'h31 + i);
    return 8'(seed + i * 13);
  endfunction

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      if (prev_last) chk(status_valid, "R9", "strobe after last", {31'h0, status_valid}, 32'h1);
      prev_last = out_valid && out_last;
      if (out_valid) begin
        if (exp_b.size() == 0) begin
          chk(0, "R6/R8", "unexpected byte", {23'h0, out_last, out_data}, 32'h0);
        end else begin
          logic [8:0] e;
          string t;
          e = exp_b.pop_front();
          t = tag_b.pop_front();
          chk({out_last, out_data} == e, t, "byte", {23'h0, out_last, out_data}, {23'h0, e});
        end
      end
      if (status_valid) begin
        if (exp_s.size() == 0) begin
          chk(0, "R9", "unexpected status", {23'h0, status_fid, status_late_coll,
              status_max_coll, status_underrun}, 32'h0);
        end else begin
          logic [8:0] e;
          string t;
          e = exp_s.pop_front();
          t = tag_s.pop_front();
          chk({status_fid, status_late_coll, status_max_coll, status_underrun} == e, t,
              "status", {23'h0, status_fid, status_late_coll, status_max_coll, status_underrun},
              {23'h0, e});
        end
      end
    end
  end

  task automatic send(input logic [5:0] fid, input int n, input int seed, input bit pad,
                      input bit crc, input int coll_at, input bit coll_max,
                      input int stop_at, input int stall_at, input string tag);
    logic [31:0] c;
    bit padding;
    int total;
    c = 32'hFFFF_FFFF;
    padding = pad && crc;
    if (stall_at >= 0) begin
      for (int i = 0; i < stall_at; i++) begin
        exp_b.push_back({1'b0, gen_byte(seed, i)});
        tag_b.push_back(tag);
      end
      exp_s.push_back({fid, 1'b0, 1'b0, 1'b1});
      tag_s.push_back(tag);
    end else begin
      for (int i = 0; i < n; i++) begin
        exp_b.push_back({(!padding || n >= 60) && !crc && i == n - 1, gen_byte(seed, i)});
        tag_b.push_back(tag);
        c = ref_crc(c, gen_byte(seed, i));
      end
      total = n;
      if (padding) begin
        for (int i = n; i < 60; i++) begin
          exp_b.push_back(9'h000);
          tag_b.push_back(tag);
          c = ref_crc(c, 8'h00);
          total++;
        end
      end
      if (crc) begin
        if (seed < 0 && n == 9) chk(~c == 32'hCBF43926, "R2", "check value", ~c, 32'hCBF43926);
        for (int k = 0; k < 4; k++) begin
          exp_b.push_back({k == 3, 8'(~c >> (8 * k))});
          tag_b.push_back(tag);
        end
      end
      exp_s.push_back({fid, coll_at >= 0 && !coll_max, coll_at >= 0 && coll_max, 1'b0});
      tag_s.push_back(tag);
    end
    pad_enable = pad;
    crc_enable = crc;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      late_coll = 1'b0;
      max_coll  = 1'b0;
      if (i == stall_at) begin
        in_valid = 1'b0;
        break;
      end
      in_valid  = 1'b1;
      in_data   = gen_byte(seed, i);
      in_last   = (i == n - 1);
      in_fid    = fid;
      late_coll = (i == coll_at) && !coll_max;
      max_coll  = (i == coll_at) && coll_max;
      if (i == stop_at) tx_enable = 1'b0;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    if (stall_at < 0 && crc && (padding && n < 60 || !padding || n >= 60))
      chk(!in_ready, "R11", "ready during trailer", {31'h0, in_ready}, 32'h0);
    in_valid  = 1'b0;
    in_last   = 1'b0;
    late_coll = 1'b0;
    max_coll  = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 500; i++) begin
      if (exp_b.size() == 0 && exp_s.size() == 0) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk(exp_b.size() == 0, "R1", "missing bytes", exp_b.size(), 0);
    chk(exp_s.size() == 0, "R9", "missing status", exp_s.size(), 0);
  endtask

  task automatic hold_blocked(input string tag);
    in_valid = 1'b1;
    in_data  = 8'hA5;
    in_last  = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!in_ready, tag, "in_ready while blocked", {31'h0, in_ready}, 32'h0);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tx_enable = 1'b0; pad_enable = 1'b0; crc_enable = 1'b0;
    in_valid = 1'b1; in_data = 8'h00; in_last = 1'b0; in_fid = '0;
    late_coll = 1'b0; max_coll = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1", "reset out_valid", {31'h0, out_valid}, 0);
    chk(!status_valid, "R9", "reset status_valid", {31'h0, status_valid}, 0);
    chk(!status_underrun, "R8", "reset underrun", {31'h0, status_underrun}, 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    hold_blocked("R6");
    tx_enable = 1'b1;
    // R1 plain
    send(6'd1, 5, 10, 0, 0, -1, 0, -1, -1, "R1");
    // R2 known vector
    send(6'd2, 9, -1, 0, 1, -1, 0, -1, -1, "R2");
    // R3 short frames padded
    send(6'd3, 10, 77, 1, 1, -1, 0, -1, -1, "R3");
    send(6'd6, 59, 5, 1, 1, -1, 0, -1, -1, "R3");
    // R4 no pad at or above 60
    send(6'd4, 60, 21, 1, 1, -1, 0, -1, -1, "R4");
    send(6'd5, 70, 33, 1, 1, -1, 0, -1, -1, "R4");
    // R5 pad without crc ignored
    send(6'd7, 10, 44, 1, 0, -1, 0, -1, -1, "R5");
    // R10 collisions, per frame
    send(6'd8, 20, 9, 0, 1, 5, 0, -1, -1, "R10");
    send(6'd9, 8, 3, 0, 0, 3, 1, -1, -1, "R10");
    send(6'd10, 8, 4, 0, 0, -1, 0, -1, -1, "R10");
    // R9 back-to-back single-byte frames
    send(6'd11, 1, 90, 0, 0, -1, 0, -1, -1, "R9");
    send(6'd12, 1, 91, 0, 0, -1, 0, -1, -1, "R9");
    drain();
    // R7 stop mid-frame, frame completes
    send(6'd13, 30, 60, 1, 1, -1, 0, 4, -1, "R7");
    drain();
    hold_blocked("R6");
    tx_enable = 1'b1;
    send(6'd14, 3, 70, 0, 0, -1, 0, -1, -1, "R6");
    drain();
    // R8 underrun
    send(6'd15, 12, 80, 0, 1, -1, 0, -1, 6, "R8");
    drain();
    chk(status_underrun, "R8", "underrun sticky", {31'h0, status_underrun}, 1);
    hold_blocked("R8");
    repeat (5) @(negedge clk);
    chk(status_underrun, "R8", "underrun still set", {31'h0, status_underrun}, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!status_underrun, "R8", "reset clears underrun", {31'h0, status_underrun}, 0);
    rst_n = 1'b1;
    prev_last = 0;
    send(6'd16, 4, 12, 0, 1, -1, 0, -1, -1, "R8");
    drain();
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule